// File: doc/BRIEF.md
# Serial EEPROM Word Access Controller

This block performs 16-bit word reads and writes on a serial EEPROM attached through a four-wire SPI bus. A host pulses `start_i` with a direction, a word offset and a word count. The controller then arbitrates for the bus through a request/grant pair and polls the device status until the device is ready. It sends the command and the byte address and moves the data words. It finishes with a one-cycle `done_o` pulse, and `err_o` is valid in that same cycle.

Read words leave the block one per `rd_valid_o` pulse. Write words enter one per `wr_ready_o` cycle; the word on `wr_data_i` is taken in that cycle. A write that crosses a device page boundary is split into segments. Between segments the controller waits the programmed write-cycle time, gives up the bus, and then runs the whole command sequence again. All timing values (SPI half period, write wait, retry limits) are parameters counted in system clock cycles.

Top module: `spi_eeprom_word_ctrl`

## Requirements
- R1: A request whose offset is at or beyond `WORD_SIZE`, whose count is zero, or whose count exceeds `WORD_SIZE - offset` is rejected. `done_o` and `err_o` pulse the cycle after `start_i`. `nvm_req_o` never rises and `spi_csn_o` stays high.
- R2: Output bits are sent MSB first. MOSI is set one half period (`HALF` clocks) before SCK rises. SCK stays high for one half period and low for one half period. MOSI returns to 0 after the last bit. SCK is only ever high while `spi_csn_o` is low.
- R3: Input bits are read by raising SCK and sampling MISO at the end of the high half period, MSB first. MOSI is held at 0 throughout.
- R4: Before each command the controller sends status opcode 0x05 and reads 8 status bits, repeating until bit 0 reads 0. If `STAT_RETRY` polls all read busy, the operation ends with `err_o` = 1.
- R5: Between the ready status poll and the next command, and after a busy poll, CS is pulsed high for one half period and then driven low again. A read on a ready device therefore lowers CS exactly twice.
- R6: When `ADDR_BITS` is 8 and the start offset is 128 or more, bit 3 (0x08) is ORed into the read opcode 0x03 and the write opcode 0x02.
- R7: The address sent is the byte address, twice the word offset. Each word is little-endian in the device: the low byte is at the even byte address.
- R8: A read sends the opcode and address once and then streams every requested word, relying on device auto-increment. There is one `rd_valid_o` pulse per word in offset order, and CS stays low while each word is presented.
- R9: A write sends write-enable opcode 0x06, a standby pulse, the write opcode, the address, and then the data words. After a word whose next byte address is a multiple of `PAGE_BYTES`, the segment ends. The controller raises CS, waits `WR_WAIT` clocks, releases the bus and restarts at grant arbitration for the remaining words. `wr_ready_o` is high only while CS is low during a write.
- R10: `nvm_req_o` is high during any bus activity. If no grant arrives within `GNT_TRIES` polls, the request drops and `err_o` = 1. On completion CS goes high and the request clears.
- R11: After reset: `spi_csn_o` = 1, `spi_sck_o` = 0, `spi_mosi_o` = 0, `nvm_req_o` = 0, `busy_o` = 0, and no valid, ready or done outputs are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted while idle |
| write_i | input | 1 | 1 = write, 0 = read |
| offset_i | input | OFF_W | Starting word offset |
| count_i | input | OFF_W | Number of words |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with `done_o` |
| rd_valid_o | output | 1 | Read word valid pulse |
| rd_data_o | output | 16 | Read word |
| wr_ready_o | output | 1 | Write word taken this cycle |
| wr_data_i | input | 16 | Write word |
| nvm_req_o | output | 1 | Bus access request |
| nvm_gnt_i | input | 1 | Bus access grant |
| spi_csn_o | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to device |
| spi_miso_i | input | 1 | Serial data from device |

## Verification
A rejected request is due exactly one clock after `start_i`, so that result is sampled at the next falling edge. Every other result depends on the number of busy polls and on the grant delay. The scoreboard therefore matches read words and completion flags in order as each `rd_valid_o` or `done_o` pulse appears, always sampling on the falling clock edge. Bit-level timing is judged by a bus-side device model: at each SCK rise it measures the time since MOSI last changed against one half period. The same model counts CS falls, segment commits and page-crossing writes, and these counts are compared after each operation.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_HIADR = 8'h08;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SETUP,
        SH_HI,
        SH_LO
    } sh_ph_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ACQ,
        S_PREP,
        S_POLL,
        S_STAT,
        S_SB,
        S_WREN,
        S_CMD,
        S_ADDR,
        S_RD,
        S_FETCH,
        S_WR,
        S_WAIT,
        S_REL,
        S_FIN
    } st_t;

endpackage

// File: rtl/spi_ee_bounds.sv
module spi_ee_bounds #(
    parameter int OFF_W     = 16,
    parameter int WORD_SIZE = 256
) (
    input  logic [OFF_W-1:0] offset_i,
    input  logic [OFF_W-1:0] count_i,
    output logic             bad_o
);
    localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(WORD_SIZE);

    logic [OFF_W:0] off_x;
    logic [OFF_W:0] cnt_x;
    logic [OFF_W:0] room;

    always_comb begin
        off_x = {1'b0, offset_i};
        cnt_x = {1'b0, count_i};
        room  = LIMIT - off_x;
        bad_o = (off_x >= LIMIT) || (cnt_x == '0) || (cnt_x > room);
    end
endmodule

// File: rtl/spi_ee_shift.sv
module spi_ee_shift
    import spi_ee_pkg::*;
#(
    parameter int HALF = 2,
    parameter int W    = 16,
    parameter int NB_W = $clog2(W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            dir_in_i,
    input  logic [NB_W-1:0] nbits_i,
    input  logic [W-1:0]    tx_i,
    input  logic            miso_i,
    output logic            done_o,
    output logic [W-1:0]    rx_o,
    output logic            sck_o,
    output logic            mosi_o
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        sh_ph_t          ph;
        logic [CNT_W-1:0] cnt;
        logic [NB_W-1:0]  left;
        logic [W-1:0]     sh;
        logic [W-1:0]     rx;
        logic             dir_in;
        logic             sck;
        logic             mosi;
        logic             done;
    } sh_t;

    sh_t q, n;
    logic half_end;
    logic [W-1:0] aligned;

    assign half_end = (q.cnt == CNT_W'(HALF - 1));
    assign aligned  = tx_i << (NB_W'(W) - nbits_i);

    always_comb begin
        n      = q;
        n.done = 1'b0;
        case (q.ph)
            SH_IDLE: begin
                if (start_i) begin
                    n.sh     = aligned;
                    n.left   = nbits_i;
                    n.rx     = '0;
                    n.cnt    = '0;
                    n.dir_in = dir_in_i;
                    if (dir_in_i) begin
                        n.mosi = 1'b0;
                        n.sck  = 1'b1;
                        n.ph   = SH_HI;
                    end else begin
                        n.mosi = aligned[W-1];
                        n.ph   = SH_SETUP;
                    end
                end
            end
            SH_SETUP: begin
                if (half_end) begin
                    n.cnt = '0;
                    n.sck = 1'b1;
                    n.ph  = SH_HI;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            SH_HI: begin
                if (half_end) begin
                    n.cnt = '0;
                    n.sck = 1'b0;
                    if (q.dir_in) n.rx = {q.rx[W-2:0], miso_i};
                    n.ph  = SH_LO;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (half_end) begin
                    n.cnt = '0;
                    if (q.left == NB_W'(1)) begin
                        n.left = '0;
                        n.done = 1'b1;
                        n.mosi = 1'b0;
                        n.ph   = SH_IDLE;
                    end else begin
                        n.left = q.left - 1'b1;
                        if (q.dir_in) begin
                            n.sck = 1'b1;
                            n.ph  = SH_HI;
                        end else begin
                            n.sh   = q.sh << 1;
                            n.mosi = q.sh[W-2];
                            n.ph   = SH_SETUP;
                        end
                    end
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: SH_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign done_o = q.done;
    assign rx_o   = q.rx;
    assign sck_o  = q.sck;
    assign mosi_o = q.mosi;

    // R3: MOSI stays low for the whole of an input transfer
    p_in_mosi_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dir_in && q.ph != SH_IDLE) |-> !mosi_o);
    // R2: data does not move while SCK is high in an output transfer
    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == SH_HI && !q.dir_in && $past(q.ph) == SH_HI) |-> $stable(mosi_o));
    // R2: the finished transfer leaves SCK and MOSI low
    p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!sck_o && !mosi_o));
endmodule

// File: rtl/spi_eeprom_word_ctrl.sv
module spi_eeprom_word_ctrl
    import spi_ee_pkg::*;
#(
    parameter int OFF_W      = 16,
    parameter int WORD_SIZE  = 256,
    parameter int ADDR_BITS  = 8,
    parameter int OP_BITS    = 8,
    parameter int PAGE_BYTES = 16,
    parameter int HALF       = 2,
    parameter int WR_WAIT    = 2000000,
    parameter int STAT_RETRY = 1000,
    parameter int GNT_TRIES  = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             write_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [OFF_W-1:0] count_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             rd_valid_o,
    output logic [15:0]      rd_data_o,
    output logic             wr_ready_o,
    input  logic [15:0]      wr_data_i,
    output logic             nvm_req_o,
    input  logic             nvm_gnt_i,
    output logic             spi_csn_o,
    output logic             spi_sck_o,
    output logic             spi_mosi_o,
    input  logic             spi_miso_i
);
    localparam int NB_W     = 5;
    localparam int PW       = PAGE_BYTES / 2;
    localparam int PW_BITS  = (PW > 1) ? $clog2(PW) : 1;
    localparam int SB_LAST  = 2 * HALF - 1;
    localparam logic [OFF_W-1:0] PW_MASK = OFF_W'(PW - 1);

    typedef struct packed {
        st_t              st;
        st_t              ret;
        logic [31:0]      tmr;
        logic [31:0]      tries;
        logic             cs;
        logic             req;
        logic             is_wr;
        logic             fail;
        logic             launched;
        logic             go;
        logic [OFF_W-1:0] off;
        logic [OFF_W-1:0] left;
        logic [15:0]      wdata;
        logic [15:0]      rdata;
        logic             rvalid;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t q, n;

    logic             bad;
    logic             sh_dir_in;
    logic [NB_W-1:0]  sh_bits;
    logic [15:0]      sh_tx;
    logic             sh_done;
    logic [15:0]      sh_rx;
    logic [OFF_W:0]   baddr;
    logic [7:0]       opc_rw;
    logic             page_end;

    spi_ee_bounds #(.OFF_W(OFF_W), .WORD_SIZE(WORD_SIZE)) u_bounds (
        .offset_i (offset_i),
        .count_i  (count_i),
        .bad_o    (bad)
    );

    spi_ee_shift #(.HALF(HALF), .W(16), .NB_W(NB_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (q.go),
        .dir_in_i (sh_dir_in),
        .nbits_i  (sh_bits),
        .tx_i     (sh_tx),
        .miso_i   (spi_miso_i),
        .done_o   (sh_done),
        .rx_o     (sh_rx),
        .sck_o    (spi_sck_o),
        .mosi_o   (spi_mosi_o)
    );

    assign baddr    = {q.off, 1'b0};
    assign page_end = (((q.off + 1'b1) & PW_MASK) == '0) && (PW_BITS > 0);

    always_comb begin
        opc_rw = q.is_wr ? OPC_WRITE : OPC_READ;
        if ((ADDR_BITS == 8) && (q.off >= OFF_W'(128))) opc_rw = opc_rw | OPC_HIADR;
    end

    // Shift job selected by the current state; the engine latches it on go.
    always_comb begin
        sh_dir_in = 1'b0;
        sh_bits   = NB_W'(OP_BITS);
        sh_tx     = '0;
        case (q.st)
            S_POLL: sh_tx = 16'(OPC_RDSR);
            S_STAT: begin sh_dir_in = 1'b1; sh_bits = NB_W'(8); end
            S_WREN: sh_tx = 16'(OPC_WREN);
            S_CMD:  sh_tx = 16'(opc_rw);
            S_ADDR: begin sh_bits = NB_W'(ADDR_BITS); sh_tx = baddr[15:0]; end
            S_RD:   begin sh_dir_in = 1'b1; sh_bits = NB_W'(16); end
            S_WR:   begin sh_bits = NB_W'(16); sh_tx = {q.wdata[7:0], q.wdata[15:8]}; end
            default: ;
        endcase
    end

    always_comb begin
        n        = q;
        n.go     = 1'b0;
        n.done   = 1'b0;
        n.err    = 1'b0;
        n.rvalid = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (bad) begin
                        n.done = 1'b1;
                        n.err  = 1'b1;
                    end else begin
                        n.off   = offset_i;
                        n.left  = count_i;
                        n.is_wr = write_i;
                        n.fail  = 1'b0;
                        n.req   = 1'b1;
                        n.tries = '0;
                        n.st    = S_ACQ;
                    end
                end
            end
            S_ACQ: begin
                if (nvm_gnt_i) begin
                    n.cs  = 1'b0;
                    n.tmr = '0;
                    n.st  = S_PREP;
                end else if (q.tries == 32'(GNT_TRIES - 1)) begin
                    n.req  = 1'b0;
                    n.done = 1'b1;
                    n.err  = 1'b1;
                    n.st   = S_IDLE;
                end else begin
                    n.tries = q.tries + 32'd1;
                end
            end
            S_PREP: begin
                if (q.tmr == 32'(HALF - 1)) begin
                    n.tmr   = '0;
                    n.tries = '0;
                    n.st    = S_POLL;
                end else begin
                    n.tmr = q.tmr + 32'd1;
                end
            end
            S_SB: begin
                if (q.tmr == 32'(HALF - 1)) n.cs = 1'b0;
                if (q.tmr == 32'(SB_LAST)) begin
                    n.tmr = '0;
                    n.st  = q.ret;
                end else begin
                    n.tmr = q.tmr + 32'd1;
                end
            end
            S_FETCH: begin
                n.wdata = wr_data_i;
                n.st    = S_WR;
            end
            S_WAIT: begin
                if (q.tmr == 32'(WR_WAIT - 1)) begin
                    n.tmr = '0;
                    n.st  = S_REL;
                end else begin
                    n.tmr = q.tmr + 32'd1;
                end
            end
            S_REL: begin
                n.req = 1'b0;
                n.cs  = 1'b1;
                n.st  = S_FIN;
            end
            S_FIN: begin
                if (!q.fail && q.left != '0) begin
                    n.req   = 1'b1;
                    n.tries = '0;
                    n.st    = S_ACQ;
                end else begin
                    n.done = 1'b1;
                    n.err  = q.fail;
                    n.st   = S_IDLE;
                end
            end
            default: begin
                if (!q.launched) begin
                    n.go       = 1'b1;
                    n.launched = 1'b1;
                end else if (sh_done) begin
                    n.launched = 1'b0;
                    case (q.st)
                        S_POLL: n.st = S_STAT;
                        S_STAT: begin
                            if (!sh_rx[0]) begin
                                n.cs  = 1'b1;
                                n.tmr = '0;
                                n.ret = q.is_wr ? S_WREN : S_CMD;
                                n.st  = S_SB;
                            end else if (q.tries == 32'(STAT_RETRY - 1)) begin
                                n.fail = 1'b1;
                                n.st   = S_REL;
                            end else begin
                                n.tries = q.tries + 32'd1;
                                n.cs    = 1'b1;
                                n.tmr   = '0;
                                n.ret   = S_POLL;
                                n.st    = S_SB;
                            end
                        end
                        S_WREN: begin
                            n.cs  = 1'b1;
                            n.tmr = '0;
                            n.ret = S_CMD;
                            n.st  = S_SB;
                        end
                        S_CMD:  n.st = S_ADDR;
                        S_ADDR: n.st = q.is_wr ? S_FETCH : S_RD;
                        S_RD: begin
                            n.rvalid = 1'b1;
                            n.rdata  = {sh_rx[7:0], sh_rx[15:8]};
                            n.off    = q.off + 1'b1;
                            n.left   = q.left - 1'b1;
                            if (q.left == OFF_W'(1)) n.st = S_REL;
                        end
                        S_WR: begin
                            n.off  = q.off + 1'b1;
                            n.left = q.left - 1'b1;
                            if (q.left == OFF_W'(1) || page_end) begin
                                n.cs  = 1'b1;
                                n.tmr = '0;
                                n.st  = S_WAIT;
                            end else begin
                                n.st = S_FETCH;
                            end
                        end
                        default: n.st = S_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, ret: S_IDLE, cs: 1'b1, default: '0};
        end else begin
            q <= n;
        end
    end

    assign busy_o     = (q.st != S_IDLE);
    assign done_o     = q.done;
    assign err_o      = q.err;
    assign rd_valid_o = q.rvalid;
    assign rd_data_o  = q.rdata;
    assign wr_ready_o = (q.st == S_FETCH);
    assign nvm_req_o  = q.req;
    assign spi_csn_o  = q.cs;

    // R1: a rejected request completes at once with an error and no bus use
    p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && bad) |=> (done_o && err_o && !nvm_req_o && spi_csn_o));
    // R2: the serial clock only toggles while the device is selected
    p_sck_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck_o |-> !spi_csn_o);
    // R10: selection is only possible while the bus request is held
    p_sel_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_csn_o |-> nvm_req_o);
    // R8: read words are presented while the read command is still open
    p_rd_in_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (!spi_csn_o && !q.is_wr));
    // R9: write words are only taken inside a selected write command
    p_wr_in_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready_o |-> (!spi_csn_o && q.is_wr));
    // R10: completion leaves the bus released
    p_done_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (spi_csn_o && !nvm_req_o));
endmodule

// File: tb/spi_eeprom_word_ctrl_bench.sv
`timescale 1ns/1ps
module spi_eeprom_word_ctrl_bench;
    localparam int HALF  = 2;
    localparam int WSIZE = 256;
    localparam real TCLK = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        write = 1'b0;
    logic [15:0] offset = '0;
    logic [15:0] count = '0;
    logic        busy, done, err, rd_valid, wr_ready, nvm_req;
    logic [15:0] rd_data;
    logic [15:0] wr_data = '0;
    logic        nvm_gnt = 1'b0;
    logic        spi_csn, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    spi_eeprom_word_ctrl #(
        .OFF_W(16), .WORD_SIZE(WSIZE), .ADDR_BITS(8), .OP_BITS(8),
        .PAGE_BYTES(16), .HALF(HALF), .WR_WAIT(40), .STAT_RETRY(4), .GNT_TRIES(6)
    ) u_spi_eeprom_word_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(write),
        .offset_i(offset), .count_i(count), .busy_o(busy), .done_o(done),
        .err_o(err), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .wr_ready_o(wr_ready), .wr_data_i(wr_data), .nvm_req_o(nvm_req),
        .nvm_gnt_i(nvm_gnt), .spi_csn_o(spi_csn), .spi_sck_o(spi_sck),
        .spi_mosi_o(spi_mosi), .spi_miso_i(spi_miso)
    );

    initial forever #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- device model and bus observers ----------------
    logic [7:0] dev_mem [0:511];
    logic [7:0] mirror  [0:511];
    logic [7:0] mshift = '0;
    logic [7:0] mop = '0;
    logic [8:0] raddr = '0;
    int  mbits = 0, mode = 0, oidx = 0, busy_cnt = 0;
    bit  wel = 0, wrote = 0, stuck = 0;
    int  cs_falls = 0, segs = 0, page_bad = 0, mosi_bad = 0, mosi_early = 0, req_rises = 0;
    realtime t_mosi = 0.0;

    always @(spi_mosi) t_mosi = $realtime;
    always @(posedge nvm_req) req_rises++;

    always @(negedge spi_csn) begin
        cs_falls++;
        mbits = 0; mode = 0; oidx = 0; wrote = 0;
    end

    always @(posedge spi_csn) begin
        if (mode == 3 && wrote) begin
            wel = 0; busy_cnt = 2; segs++;
        end
        if (mode == 1 && busy_cnt > 0) busy_cnt--;
        mode = 0;
        spi_miso = 1'b0;
    end

    always @(posedge spi_sck) if (!spi_csn) begin
        if ($realtime - t_mosi < HALF * TCLK - 0.1) mosi_early++;
        if ((mode == 1 || mode == 2) && spi_mosi) mosi_bad++;
        mshift = {mshift[6:0], spi_mosi};
        mbits++;
        if (mbits == 8) begin
            mop = mshift;
            if (mop == 8'h06) wel = 1;
            if (mop == 8'h05) begin mode = 1; oidx = 0; end
        end else if (mbits == 16 && mop[7:4] == 4'h0 && mop[2:0] == 3'b011) begin
            raddr = {mop[3], mshift}; mode = 2; oidx = 0;
        end else if (mbits == 16 && mop[7:4] == 4'h0 && mop[2:0] == 3'b010) begin
            raddr = {mop[3], mshift}; mode = 3;
        end else if (mode == 3 && mbits > 16 && (mbits % 8) == 0 && wel) begin
            if (wrote && raddr[3:0] == 4'h0) page_bad++;
            dev_mem[raddr] = mshift;
            raddr = raddr + 9'd1;
            wrote = 1;
        end
    end

    always @(negedge spi_sck) if (!spi_csn) begin
        if (mode == 1) begin
            spi_miso = (oidx == 7) ? (stuck || busy_cnt > 0) : 1'b0;
            oidx++;
        end else if (mode == 2) begin
            spi_miso = dev_mem[raddr][7 - oidx];
            oidx++;
            if (oidx == 8) begin oidx = 0; raddr = raddr + 9'd1; end
        end
    end

    // grant source
    bit gnt_en = 1;
    initial forever begin
        @(negedge clk);
        nvm_gnt = gnt_en && nvm_req;
    end

    // write data source: advance after each taken word
    logic [15:0] wbuf [0:15];
    int  widx = 0;
    bit  taken = 0;
    initial forever begin
        @(negedge clk);
        if (taken) begin widx++; taken = 0; end
        if (wr_ready) taken = 1;
        wr_data = wbuf[widx];
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_rd [$];
    bit          exp_err [$];
    string       exp_tag [$];
    int          done_cnt = 0;

    initial forever begin
        @(negedge clk);
        if (rd_valid) begin
            if (exp_rd.size() == 0) chk(0, "R8 unexpected word", rd_data, 0);
            else begin
                logic [15:0] e;
                e = exp_rd.pop_front();
                chk(rd_data == e, "R7/R8 read word", rd_data, e);
            end
        end
        if (done) begin
            if (exp_err.size() == 0) chk(0, "R10 unexpected done", err, 0);
            else begin
                bit ee;
                string t;
                ee = exp_err.pop_front();
                t  = exp_tag.pop_front();
                chk(err == ee, t, err, ee);
            end
            done_cnt++;
        end
    end

    function automatic logic [15:0] mword(input int w);
        return {mirror[2*w + 1], mirror[2*w]};
    endfunction

    task automatic run_op(input bit wr, input int off, input int cnt, input bit ee, input string tag);
        int d0;
        if (!wr && !ee) for (int k = 0; k < cnt; k++) exp_rd.push_back(mword(off + k));
        exp_err.push_back(ee);
        exp_tag.push_back(tag);
        widx = 0;
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b1; write = wr; offset = 16'(off); count = 16'(cnt);
        @(negedge clk);
        start = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        if (wr && !ee) for (int k = 0; k < cnt; k++) begin
            mirror[2*(off + k)]     = wbuf[k][7:0];
            mirror[2*(off + k) + 1] = wbuf[k][15:8];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int f0, r0, s0;
        for (int i = 0; i < 512; i++) begin
            dev_mem[i] = 8'((i * 37 + 11) & 255);
            mirror[i]  = 8'((i * 37 + 11) & 255);
        end
        for (int i = 0; i < 16; i++) wbuf[i] = 16'hA500 + 16'(i * 17);
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(spi_csn == 1 && spi_sck == 0 && spi_mosi == 0, "R11 bus idle", {spi_csn, spi_sck, spi_mosi}, 3'b100);
        chk(!nvm_req && !busy && !done && !rd_valid && !wr_ready, "R11 handshake idle",
            {nvm_req, busy, done, rd_valid, wr_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: bounds rejection, bus untouched
        f0 = cs_falls; r0 = req_rises;
        run_op(0, 256, 1, 1, "R1 offset beyond size");
        run_op(0, 10, 0, 1, "R1 zero count");
        run_op(1, 250, 7, 1, "R1 count past end");
        chk(cs_falls == f0, "R1 CS untouched", cs_falls, f0);
        chk(req_rises == r0, "R1 request untouched", req_rises, r0);

        // R8/R7/R5: plain read, ready device
        f0 = cs_falls;
        run_op(0, 0, 4, 0, "R8 read done");
        chk(cs_falls == f0 + 2, "R5 one standby before read", cs_falls, f0 + 2);
        chk(spi_csn == 1 && !nvm_req, "R10 released after read", {spi_csn, nvm_req}, 2'b10);

        // R6: high-half addresses and crossing of offset 128
        run_op(0, 130, 3, 0, "R6 read above 128");
        run_op(0, 126, 4, 0, "R6 read across 128");

        // R9: write crossing a page (8 words per page): 6,7 | 8,9,10
        s0 = segs;
        run_op(1, 6, 5, 0, "R9 split write");
        chk(segs == s0 + 2, "R9 segment count", segs, s0 + 2);
        chk(page_bad == 0, "R9 no page crossing", page_bad, 0);
        run_op(0, 4, 8, 0, "R7 readback after split write");

        // R6: write in the high half then read it back
        for (int i = 0; i < 16; i++) wbuf[i] = 16'h3C00 + 16'(i * 5);
        run_op(1, 200, 2, 0, "R6 write above 128");
        run_op(0, 199, 4, 0, "R6 readback above 128");

        // R8: read to the last word
        run_op(0, 250, 6, 0, "R8 read to end");

        // R4: device never ready
        stuck = 1;
        run_op(0, 0, 1, 1, "R4 status retry limit");
        chk(!nvm_req && spi_csn, "R4 released after status error", {nvm_req, spi_csn}, 2'b01);
        stuck = 0;

        // R10: grant never arrives
        gnt_en = 0;
        f0 = cs_falls; r0 = req_rises;
        run_op(0, 0, 1, 1, "R10 grant timeout");
        chk(req_rises == r0 + 1 && !nvm_req, "R10 request dropped", req_rises, r0 + 1);
        chk(cs_falls == f0, "R10 no selection without grant", cs_falls, f0);
        gnt_en = 1;

        // R2/R3: bit timing observed across all traffic
        chk(mosi_early == 0, "R2 MOSI setup half period", mosi_early, 0);
        chk(spi_mosi == 0, "R2 MOSI low after transfer", spi_mosi, 0);
        chk(mosi_bad == 0, "R3 MOSI low while reading", mosi_bad, 0);
        chk(exp_rd.size() == 0 && exp_err.size() == 0, "R8 scoreboard drained",
            exp_rd.size() + exp_err.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule